// File: doc/BRIEF.md
# Multi-expiration watchdog timer

This block is a system watchdog whose down counter must run out five times in a row before it asks for a system reset. Software writes a reload value that is one fifth of the total timeout. It starts the counter through a command register and keeps it alive by pinging it. Each time the counter runs down, the block adds one to an expiration tally and reloads the counter by itself. The first run-out can raise an interrupt, which gives software a last chance to react before the reset request is issued.

The counter moves only on a one-cycle tick-enable input, normally a microsecond strobe, so the core clock can be much faster than the timebase. Software can read the live counter and the expiration tally at any time. The time left before reset is the live count plus (4 − tally) × the reload value, in ticks.

Register map (byte addresses): 0x0 reload (bits 28:0 reload value, bit 31 interrupt enable, read/write); 0x4 live (read: bits 28:0 live count, bit 30 interrupt pending; a write of 1 to bit 30 clears the interrupt); 0x8 command (write: bit 0 start, bit 1 stop, bit 2 ping; reads 0); 0xC state (read: bit 0 running, bit 1 reset requested, bits 14:12 expiration tally).

Top module: `multi_expiry_wdt`

## Requirements
- R1: After reset the reload, live and state registers read 0, and irq and rst_req are low.
- R2: The reload register reads back what was written, with the value in bits 28:0 and the interrupt enable in bit 31.
- R3: A start command loads the counter with the reload value, clears the tally and sets the running bit (state bit 0).
- R4: While running, the counter drops by one on each tick_us pulse. Cycles without a tick, and ticks while stopped, leave the count unchanged.
- R5: A tick that finds the count at 1 or 0 is an expiration: the tally (state bits 14:12) goes up by one and the counter reloads. The reset request therefore comes 5 × reload ticks after the start.
- R6: When the interrupt enable is set, irq rises on the first expiration only (tally 0 to 1). It does not rise on later expirations, or at all when the enable is clear. The pending flag reads in live bit 30.
- R7: Writing 1 to live bit 30 clears irq. If an interrupt-setting expiration happens in the same cycle, the set wins.
- R8: A ping while running reloads the counter and zeroes the tally, and it wins over a coincident expiration. A ping while stopped changes nothing.
- R9: A stop command freezes the counter and the tally. A later start clears the tally to 0 and reloads.
- R10: On the fifth expiration rst_req rises (state bit 1), the count goes to 0 and the tally stays at 4. rst_req stays high until a global reset, and later ticks, pings, starts and stops do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle count-enable strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | First-expiration interrupt |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The hardest case to reach is a ping or an interrupt clear that lands in the same cycle as an expiration. The bench first ticks the counter down to 1. It then issues a write and a tick pulse in one cycle, so the tie-breaking rules of R7 and R8 are seen at the ports. A second hard case is the sticky reset after a full five-period run. The bench reaches it with a small reload value, then tries every command afterwards to confirm that the request and the frozen state cannot be disturbed.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // word index taken from bus_addr[3:2]
  localparam int unsigned REG_RELOAD = 0;
  localparam int unsigned REG_LIVE   = 1;
  localparam int unsigned REG_CMD    = 2;
  localparam int unsigned REG_STATE  = 3;

  localparam int unsigned CMD_START_BIT = 0;
  localparam int unsigned CMD_STOP_BIT  = 1;
  localparam int unsigned CMD_PING_BIT  = 2;
  localparam int unsigned IRQ_EN_BIT    = 31;
  localparam int unsigned IRQ_FLAG_BIT  = 30;
  localparam int unsigned RUN_BIT       = 0;
  localparam int unsigned RSTREQ_BIT    = 1;
  localparam int unsigned TALLY_LSB     = 12;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 29,
  parameter int unsigned TALLY_W = 3,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]   live_cnt,
  input  logic [TALLY_W-1:0] tally,
  input  logic               running,
  input  logic               rst_flag,
  input  logic               irq_flag,
  output logic [CNT_W-1:0]   reload_val,
  output logic               irq_en,
  output logic               cmd_start,
  output logic               cmd_stop,
  output logic               cmd_ping,
  output logic               irq_clr,
  output logic [DATA_W-1:0]  bus_rdata
);
  logic [1:0]       word_sel;
  logic             reload_we;
  logic [CNT_W-1:0] reload_d;
  logic             irq_en_d;

  assign word_sel  = bus_addr[3:2];
  assign reload_we = bus_wr && (word_sel == 2'(REG_RELOAD));
  assign cmd_start = bus_wr && (word_sel == 2'(REG_CMD)) && bus_wdata[CMD_START_BIT];
  assign cmd_stop  = bus_wr && (word_sel == 2'(REG_CMD)) && bus_wdata[CMD_STOP_BIT];
  assign cmd_ping  = bus_wr && (word_sel == 2'(REG_CMD)) && bus_wdata[CMD_PING_BIT];
  assign irq_clr   = bus_wr && (word_sel == 2'(REG_LIVE)) && bus_wdata[IRQ_FLAG_BIT];

  always_comb begin
    reload_d = reload_val;
    irq_en_d = irq_en;
    if (reload_we) begin
      reload_d = bus_wdata[CNT_W-1:0];
      irq_en_d = bus_wdata[IRQ_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_val <= '0;
      irq_en     <= 1'b0;
    end else if (reload_we) begin
      reload_val <= reload_d;
      irq_en     <= irq_en_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (word_sel)
      2'(REG_RELOAD): begin
        bus_rdata[CNT_W-1:0]  = reload_val;
        bus_rdata[IRQ_EN_BIT] = irq_en;
      end
      2'(REG_LIVE): begin
        bus_rdata[CNT_W-1:0]    = live_cnt;
        bus_rdata[IRQ_FLAG_BIT] = irq_flag;
      end
      2'(REG_STATE): begin
        bus_rdata[RUN_BIT]                  = running;
        bus_rdata[RSTREQ_BIT]               = rst_flag;
        bus_rdata[TALLY_LSB +: TALLY_W]     = tally;
      end
      default: bus_rdata = '0;
    endcase
  end

  // R3: a start strobe only comes from a write
  a_r3_cmd_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start || cmd_stop || cmd_ping) |-> bus_wr);
  // R2: the reload register changes only on a write to it
  a_r2_reload_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_we |=> $stable(reload_val));
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int unsigned CNT_W     = 29,
  parameter int unsigned EXP_LIMIT = 5,
  parameter int unsigned TALLY_W   = $clog2(EXP_LIMIT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [CNT_W-1:0]   reload_val,
  input  logic               irq_en,
  input  logic               cmd_start,
  input  logic               cmd_stop,
  input  logic               cmd_ping,
  input  logic               irq_clr,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [TALLY_W-1:0] tally_q,
  output logic               run_q,
  output logic               rst_q,
  output logic               irq_q
);
  localparam logic [TALLY_W-1:0] LAST_TALLY = TALLY_W'(EXP_LIMIT - 1);

  logic [CNT_W-1:0]   cnt_d;
  logic [TALLY_W-1:0] tally_d;
  logic               run_d, rst_d, irq_d;
  logic               live, run_out;

  assign live    = run_q && !rst_q;
  assign run_out = cnt_q < CNT_W'(2);

  always_comb begin
    cnt_d   = cnt_q;
    tally_d = tally_q;
    run_d   = run_q;
    rst_d   = rst_q;
    irq_d   = irq_q && !irq_clr;
    if (cmd_stop) begin
      run_d = 1'b0;
    end else if (cmd_start && !rst_q) begin
      run_d   = 1'b1;
      cnt_d   = reload_val;
      tally_d = '0;
    end else if (cmd_ping && live) begin
      cnt_d   = reload_val;
      tally_d = '0;
    end else if (tick && live) begin
      if (run_out) begin
        if (tally_q == LAST_TALLY) begin
          rst_d = 1'b1;
          cnt_d = '0;
        end else begin
          tally_d = tally_q + 1'b1;
          cnt_d   = reload_val;
          if (tally_q == '0 && irq_en) irq_d = 1'b1;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tally_q <= '0;
      run_q   <= 1'b0;
      rst_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      tally_q <= tally_d;
      run_q   <= run_d;
      rst_q   <= rst_d;
      irq_q   <= irq_d;
    end
  end

  // R10: reset request is sticky
  a_r10_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);
  // R10: request rises only with tally at its last value and count at zero
  a_r10_rst_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> (tally_q == LAST_TALLY) && (cnt_q == '0));
  // R5: tally never leaves its range
  a_r5_tally_range: assert property (@(posedge clk) disable iff (!rst_n)
    tally_q <= LAST_TALLY);
  // R4, R9: stopped counter holds unless started
  a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cmd_start) |=> $stable(cnt_q) && $stable(tally_q));
  // R8: accepted ping clears the tally
  a_r8_ping_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ping && live && !cmd_stop) |=> tally_q == '0);
  // R6: interrupt rises only on the first expiration
  a_r6_irq_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> tally_q == TALLY_W'(1));
endmodule

// File: rtl/multi_expiry_wdt.sv
module multi_expiry_wdt #(
  parameter int unsigned CNT_W     = 29,
  parameter int unsigned EXP_LIMIT = 5,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  localparam int unsigned TALLY_W = $clog2(EXP_LIMIT);

  logic [1:0]         sync_q;
  logic               rst_sync_n;
  logic [CNT_W-1:0]   cnt, reload_val;
  logic [TALLY_W-1:0] tally;
  logic               running, rst_flag, irq_flag, irq_en;
  logic               cmd_start, cmd_stop, cmd_ping, irq_clr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  wdt_regs #(.CNT_W(CNT_W), .TALLY_W(TALLY_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_sync_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .live_cnt(cnt), .tally(tally), .running(running),
    .rst_flag(rst_flag), .irq_flag(irq_flag), .reload_val(reload_val),
    .irq_en(irq_en), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_ping(cmd_ping), .irq_clr(irq_clr), .bus_rdata(bus_rdata)
  );

  wdt_core #(.CNT_W(CNT_W), .EXP_LIMIT(EXP_LIMIT), .TALLY_W(TALLY_W)) core_i (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick_us), .reload_val(reload_val),
    .irq_en(irq_en), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_ping(cmd_ping), .irq_clr(irq_clr), .cnt_q(cnt), .tally_q(tally),
    .run_q(running), .rst_q(rst_flag), .irq_q(irq_flag)
  );

  assign irq     = irq_flag;
  assign rst_req = rst_flag;
endmodule

// File: tb/multi_expiry_wdt_tb_top.sv
module multi_expiry_wdt_tb_top;
  typedef struct {
    string       tag;
    logic [31:0] val;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_us = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  item_t exp_q[$];
  item_t obs_q[$];

  always #2 clk = ~clk;

  multi_expiry_wdt dut_i (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req)
  );

  localparam logic [3:0] A_RELOAD = 4'h0, A_LIVE = 4'h4, A_CMD = 4'h8, A_STATE = 4'hC;
  localparam logic [31:0] C_START = 32'h1, C_STOP = 32'h2, C_PING = 32'h4;
  localparam logic [31:0] IRQ_EN = 32'h8000_0000, IRQ_CLR = 32'h4000_0000;

  function automatic logic [31:0] st(int tally, bit rq, bit run);
    return (32'(tally) << 12) | (32'(rq) << 1) | 32'(run);
  endfunction
  function automatic logic [31:0] lv(int cnt, bit ip);
    return 32'(cnt) | (32'(ip) << 30);
  endfunction

  // monitor: compares observed against expected in order
  always @(posedge clk) begin
    while (exp_q.size() > 0 && obs_q.size() > 0) begin
      item_t e, o;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      n_vec++;
      if (e.val !== o.val) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", e.tag, o.val, e.val);
      end
    end
  end

  task automatic cyc(bit wr, logic [3:0] a, logic [31:0] d, bit tk);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; tick_us = tk;
    @(negedge clk);
    bus_wr = 1'b0; tick_us = 1'b0;
  endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'h0, 32'h0, 1'b1);
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'h0, 32'h0, 1'b0);
  endtask
  task automatic rd(logic [3:0] a, logic [31:0] e, string tag);
    bus_addr = a;
    #1;
    exp_q.push_back('{tag, e});
    obs_q.push_back('{tag, bus_rdata});
  endtask
  task automatic pin(logic act, logic e, string tag);
    exp_q.push_back('{tag, 32'(e)});
    obs_q.push_back('{tag, 32'(act)});
  endtask
  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(3);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    rd(A_RELOAD, 32'h0, "R1 reload");
    rd(A_LIVE, 32'h0, "R1 live");
    rd(A_STATE, 32'h0, "R1 state");
    pin(irq, 1'b0, "R1 irq");
    pin(rst_req, 1'b0, "R1 rst_req");

    cyc(1'b1, A_RELOAD, IRQ_EN | 32'd4, 1'b0);
    rd(A_RELOAD, IRQ_EN | 32'd4, "R2 reload readback");
    ticks(2);
    rd(A_LIVE, lv(0, 0), "R4 ticks while stopped");

    cyc(1'b1, A_CMD, C_START, 1'b0);
    rd(A_LIVE, lv(4, 0), "R3 start loads");
    rd(A_STATE, st(0, 0, 1), "R3 running");
    ticks(1);
    rd(A_LIVE, lv(3, 0), "R4 one tick");
    idle(3);
    rd(A_LIVE, lv(3, 0), "R4 no tick holds");
    ticks(3);
    rd(A_LIVE, lv(4, 1), "R5 reload on expiry");
    rd(A_STATE, st(1, 0, 1), "R5 tally 1");
    pin(irq, 1'b1, "R6 irq first expiry");

    cyc(1'b1, A_LIVE, IRQ_CLR, 1'b0);
    pin(irq, 1'b0, "R7 irq cleared");
    ticks(4);
    rd(A_STATE, st(2, 0, 1), "R5 tally 2");
    pin(irq, 1'b0, "R6 no irq second expiry");

    cyc(1'b1, A_CMD, C_PING, 1'b0);
    rd(A_STATE, st(0, 0, 1), "R8 ping clears tally");
    ticks(3);
    cyc(1'b1, A_CMD, C_PING, 1'b1);
    rd(A_LIVE, lv(4, 0), "R8 ping beats expiry");
    rd(A_STATE, st(0, 0, 1), "R8 tally after tie");

    ticks(4);
    pin(irq, 1'b1, "R6 irq after ping");
    cyc(1'b1, A_LIVE, IRQ_CLR, 1'b0);
    ticks(2);
    cyc(1'b1, A_CMD, C_STOP, 1'b0);
    ticks(3);
    rd(A_LIVE, lv(2, 0), "R9 stop freezes count");
    rd(A_STATE, st(1, 0, 0), "R9 stop freezes tally");
    cyc(1'b1, A_CMD, C_PING, 1'b0);
    rd(A_LIVE, lv(2, 0), "R8 ping ignored when stopped");
    cyc(1'b1, A_CMD, C_START, 1'b0);
    rd(A_STATE, st(0, 0, 1), "R9 restart clears tally");
    rd(A_LIVE, lv(4, 0), "R9 restart reloads");

    cyc(1'b1, A_LIVE, IRQ_CLR, 1'b0);
    ticks(19);
    rd(A_LIVE, lv(1, 1), "R5 one tick before reset");
    rd(A_STATE, st(4, 0, 1), "R5 tally 4");
    pin(rst_req, 1'b0, "R10 not yet");
    ticks(1);
    pin(rst_req, 1'b1, "R10 fifth expiry");
    rd(A_STATE, st(4, 1, 1), "R10 state at reset");
    rd(A_LIVE, lv(0, 1), "R10 count zero");
    ticks(5);
    cyc(1'b1, A_CMD, C_PING, 1'b0);
    cyc(1'b1, A_CMD, C_START, 1'b0);
    cyc(1'b1, A_CMD, C_STOP, 1'b0);
    pin(rst_req, 1'b1, "R10 sticky");
    rd(A_STATE, st(4, 1, 0), "R10 frozen tally");
    rd(A_LIVE, lv(0, 1), "R10 frozen count");

    do_reset();
    pin(rst_req, 1'b0, "R1 cleared by reset");
    cyc(1'b1, A_RELOAD, 32'd3, 1'b0);
    cyc(1'b1, A_CMD, C_START, 1'b0);
    ticks(3);
    rd(A_STATE, st(1, 0, 1), "R6 expiry without enable");
    pin(irq, 1'b0, "R6 irq masked");

    cyc(1'b1, A_RELOAD, IRQ_EN | 32'd3, 1'b0);
    cyc(1'b1, A_CMD, C_START, 1'b0);
    ticks(2);
    cyc(1'b1, A_LIVE, IRQ_CLR, 1'b1);
    pin(irq, 1'b1, "R7 set wins over clear");
    rd(A_LIVE, lv(3, 1), "R7 pending flag");

    idle(2);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule